// File: doc/BRIEF.md
# Integer ALU with Two-Level Operation Decode

This block is a purely combinational 32-bit integer arithmetic/logic unit together with the small decoder that picks its operation. A main controller supplies a 2-bit operation class. Under the register-format class, the 6-bit function field of the instruction chooses the operation. The decoder turns these two inputs into a fixed 4-bit operation code. The execution datapath applies that code to two signed two's complement operands and returns a 32-bit result and a flag that is set when the result is all zeros.

The supported operations are bitwise AND, OR and NOR, wrapping add and subtract, and signed set-less-than. Load and store address computation uses the add path. The controller forces it through class 0, whatever the function field holds. Class 1 forces subtract in the same way. Codes that the decoder does not recognise give a zero result.

Top module: `int_alu_top`

## Requirements
- R1: With class 2, function 0x20 gives operation code 0010 (add), 0x22 gives 0110 (subtract), 0x24 gives 0000 (AND), 0x25 gives 0001 (OR), 0x27 gives 1100 (NOR) and 0x2A gives 0111 (set-less-than), all on op_o.
- R2: With class 0, op_o is 0010 and the result is A+B, whatever the function field holds.
- R3: With class 1, op_o is 0110 and the result is A−B, whatever the function field holds.
- R4: Class 3 decodes the function field exactly as class 2 does.
- R5: With class 2 or 3 and a function value outside the list in R1, op_o is 1111 and the result is 0 with zero_o=1.
- R6: Add returns A+B modulo 2^32.
- R7: Subtract returns A−B modulo 2^32.
- R8: AND, OR and NOR act bit by bit on A and B.
- R9: Set-less-than returns 1 in bit 0, with bits 31..1 cleared, when A<B as signed numbers. It returns all zeros otherwise, and also when A equals B.
- R10: zero_o is 1 exactly when all 32 bits of result_o are 0.
- R11: op_o, result_o and zero_o follow their inputs with no clock; a change of input shows within the same evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| class_i | input | 2 | Operation class from the main controller |
| funct_i | input | 6 | Function field of a register-format instruction |
| a_i | input | 32 | First signed operand |
| b_i | input | 32 | Second signed operand |
| op_o | output | 4 | Decoded operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | 1 when result_o is all zeros |

## Verification
Two functions can meet in one evaluation. The first is a wrapping arithmetic result, or a false or equal set-less-than. The second is the zero flag, which then has to rise along with that result. The bench provokes this with 1 + 0xFFFFFFFF, with 0xFFFFFFFF − 0xFFFFFFFF, and with set-less-than on equal operands and on a negative second operand. It judges result and flag together against values worked out from the requirements. In the same way, the forced classes are run with function fields that would select a different operation under class 2. This shows that the class override wins over the function decode.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_NOR  = 4'b1100,
    OP_NONE = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_MEM   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_RTYPE = 2'd2,
    CLS_ALT   = 2'd3
  } op_class_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
  import int_alu_pkg::*;
(
  input  logic [1:0] class_i,
  input  logic [5:0] funct_i,
  output logic [3:0] op_o
);

  alu_op_e fn_op;

  always_comb begin
    unique case (funct_i)
      FN_ADD:  fn_op = OP_ADD;
      FN_SUB:  fn_op = OP_SUB;
      FN_AND:  fn_op = OP_AND;
      FN_OR:   fn_op = OP_OR;
      FN_NOR:  fn_op = OP_NOR;
      FN_SLT:  fn_op = OP_SLT;
      default: fn_op = OP_NONE;
    endcase
  end

  always_comb begin
    unique case (op_class_e'(class_i))
      CLS_MEM: op_o = OP_ADD;
      CLS_SUB: op_o = OP_SUB;
      default: op_o = fn_op;  // class 2 and 3 both decode funct
    endcase
  end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] nor_o
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_slice
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign nor_o[i] = ~(a_i[i] | b_i[i]);
  end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_o
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};

  // signed compare: differing signs decide directly, else sign of difference
  assign lt_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : sum_o[MSB];

endmodule

// File: rtl/int_alu_exec.sv
module int_alu_exec
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o
);

  logic [DATA_W-1:0] and_v, or_v, nor_v, sum_v;
  logic              lt_v, sub_en;

  assign sub_en = (op_i == OP_SUB) || (op_i == OP_SLT);

  int_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_v),
    .or_o  (or_v),
    .nor_o (nor_v)
  );

  int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_en),
    .sum_o (sum_v),
    .lt_o  (lt_v)
  );

  always_comb begin
    case (alu_op_e'(op_i))
      OP_AND:  result_o = and_v;
      OP_OR:   result_o = or_v;
      OP_NOR:  result_o = nor_v;
      OP_ADD,
      OP_SUB:  result_o = sum_v;
      OP_SLT:  result_o = {{(DATA_W-1){1'b0}}, lt_v};
      default: result_o = '0;
    endcase
  end

endmodule

// File: rtl/int_alu_top.sv
module int_alu_top #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        class_i,
  input  logic [5:0]        funct_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [3:0]        op_o,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);

  int_alu_decode u_decode (
    .class_i (class_i),
    .funct_i (funct_i),
    .op_o    (op_o)
  );

  int_alu_exec #(.DATA_W(DATA_W)) u_exec (
    .op_i     (op_o),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o)
  );

  assign zero_o = ~|result_o;

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic [1:0]        class_i,
  input logic [5:0]        funct_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [3:0]        op_o,
  input logic [DATA_W-1:0] result_o,
  input logic              zero_o
);

  logic known;
  assign known = !$isunknown({class_i, funct_i, a_i, b_i});

  always_comb begin
    if (known) begin
      AST_CLASS_MEM_ADD: assert (class_i != 2'd0 || (op_o == OP_ADD && result_o == a_i + b_i)) else $error("class 0 not add"); // R2
      AST_CLASS_FORCE_SUB: assert (class_i != 2'd1 || (op_o == OP_SUB && result_o == a_i - b_i)) else $error("class 1 not sub"); // R3
      AST_SLT_UPPER_CLEAR: assert (op_o != OP_SLT || result_o[DATA_W-1:1] == '0) else $error("slt upper bits"); // R9
      AST_UNKNOWN_ZERO: assert (op_o != OP_NONE || (result_o == '0 && zero_o)) else $error("unknown op nonzero"); // R5
      AST_ZERO_FLAG: assert (zero_o == (result_o == '0)) else $error("zero flag mismatch"); // R10
    end
  end

endmodule

bind int_alu_top int_alu_checker #(.DATA_W(DATA_W)) u_int_alu_checker (.*);

// File: tb/int_alu_top_bench.sv
`timescale 1ns/1ps
module int_alu_top_bench;

  logic        clk = 1'b0;
  logic [1:0]  class_i = '0;
  logic [5:0]  funct_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [3:0]  op_o;
  logic [31:0] result_o;
  logic        zero_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  int_alu_top u_int_alu_top (
    .class_i  (class_i),
    .funct_i  (funct_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .op_o     (op_o),
    .result_o (result_o),
    .zero_o   (zero_o)
  );

  task automatic drive(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    class_i = c; funct_i = f; a_i = a; b_i = b;
    @(negedge clk);
  endtask

  task automatic chk_res(input string tag, input logic [31:0] exp_r, input logic exp_z);
    checks++;
    if (result_o !== exp_r || zero_o !== exp_z) begin
      errors++;
      $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
               tag, result_o, zero_o, exp_r, exp_z);
    end
  endtask

  task automatic chk_op(input string tag, input logic [3:0] exp_op);
    checks++;
    if (op_o !== exp_op) begin
      errors++;
      $display("FAIL %s: op=%b expected op=%b", tag, op_o, exp_op);
    end
  endtask

  task automatic t_initial();
    drive(2'd0, 6'h00, 32'h0, 32'h0);
    chk_op("R2 initial", 4'b0010);
    chk_res("R10 initial", 32'h0, 1'b1);
  endtask

  task automatic t_decode();
    drive(2'd2, 6'h20, 32'h0, 32'h0); chk_op("R1 fn20", 4'b0010);
    drive(2'd2, 6'h22, 32'h0, 32'h0); chk_op("R1 fn22", 4'b0110);
    drive(2'd2, 6'h24, 32'h0, 32'h0); chk_op("R1 fn24", 4'b0000);
    drive(2'd2, 6'h25, 32'h0, 32'h0); chk_op("R1 fn25", 4'b0001);
    drive(2'd2, 6'h27, 32'h0, 32'h0); chk_op("R1 fn27", 4'b1100);
    drive(2'd2, 6'h2A, 32'h0, 32'h0); chk_op("R1 fn2A", 4'b0111);
  endtask

  task automatic t_logic();
    drive(2'd2, 6'h24, 32'h1111, 32'hffff); chk_res("R8 and", 32'h1111, 1'b0);
    drive(2'd2, 6'h24, 32'h0, 32'hffff);    chk_res("R8 and zero", 32'h0, 1'b1);
    drive(2'd2, 6'h25, 32'h1111, 32'hffff); chk_res("R8 or", 32'hffff, 1'b0);
    drive(2'd2, 6'h25, 32'h0, 32'h0);       chk_res("R8 or zero", 32'h0, 1'b1);
    drive(2'd2, 6'h27, 32'h1111, 32'hffff); chk_res("R8 nor", 32'hffff0000, 1'b0);
    drive(2'd2, 6'h27, 32'h0, 32'h0);       chk_res("R8 nor zero", 32'hffffffff, 1'b0);
  endtask

  task automatic t_add();
    drive(2'd2, 6'h20, 32'h1, 32'hffff);        chk_res("R6 add", 32'h10000, 1'b0);
    drive(2'd2, 6'h20, 32'h1111, 32'hffff);     chk_res("R6 add2", 32'h11110, 1'b0);
    drive(2'd2, 6'h20, 32'h1, 32'hffffffff);    chk_res("R6 wrap", 32'h0, 1'b1);
    drive(2'd2, 6'h20, 32'h1, 32'hfffffffe);    chk_res("R6 neg", 32'hffffffff, 1'b0);
  endtask

  task automatic t_sub();
    drive(2'd2, 6'h22, 32'h1, 32'hffffffff);          chk_res("R7 sub", 32'h2, 1'b0);
    drive(2'd2, 6'h22, 32'hffffffff, 32'h1);          chk_res("R7 sub neg", 32'hfffffffe, 1'b0);
    drive(2'd2, 6'h22, 32'hffffffff, 32'hffffffff);   chk_res("R7 sub eq", 32'h0, 1'b1);
    drive(2'd2, 6'h22, 32'h1, 32'h1);                 chk_res("R7 sub one", 32'h0, 1'b1);
  endtask

  task automatic t_slt();
    drive(2'd2, 6'h2A, 32'h2, 32'h2);                 chk_res("R9 equal", 32'h0, 1'b1);
    drive(2'd2, 6'h2A, 32'h2, 32'h1);                 chk_res("R9 greater", 32'h0, 1'b1);
    drive(2'd2, 6'h2A, 32'h1, 32'h2);                 chk_res("R9 less", 32'h1, 1'b0);
    drive(2'd2, 6'h2A, 32'hffffffff, 32'h1);          chk_res("R9 neg lt", 32'h1, 1'b0);
    drive(2'd2, 6'h2A, 32'h1, 32'hffffffff);          chk_res("R9 pos gt", 32'h0, 1'b1);
    drive(2'd2, 6'h2A, 32'h80000000, 32'h7fffffff);   chk_res("R9 extreme", 32'h1, 1'b0);
  endtask

  task automatic t_forced();
    drive(2'd0, 6'h27, 32'h1, 32'hffff);  chk_op("R2 op", 4'b0010); chk_res("R2 add", 32'h10000, 1'b0);
    drive(2'd0, 6'h3F, 32'h5, 32'h7);     chk_res("R2 bad fn", 32'hc, 1'b0);
    drive(2'd1, 6'h2A, 32'hffff, 32'h1);  chk_op("R3 op", 4'b0110); chk_res("R3 sub", 32'hfffe, 1'b0);
    drive(2'd1, 6'h24, 32'h1, 32'h1);     chk_res("R3 zero", 32'h0, 1'b1);
  endtask

  task automatic t_class3();
    drive(2'd3, 6'h27, 32'h1111, 32'hffff); chk_op("R4 nor op", 4'b1100); chk_res("R4 nor", 32'hffff0000, 1'b0);
    drive(2'd3, 6'h2A, 32'hffffffff, 32'h1); chk_res("R4 slt", 32'h1, 1'b0);
    drive(2'd3, 6'h20, 32'h3, 32'h4);       chk_res("R4 add", 32'h7, 1'b0);
  endtask

  task automatic t_unknown();
    drive(2'd2, 6'h21, 32'hffffffff, 32'h1234); chk_op("R5 op", 4'b1111); chk_res("R5 zero", 32'h0, 1'b1);
    drive(2'd3, 6'h00, 32'h5, 32'h5);           chk_res("R5 class3", 32'h0, 1'b1);
  endtask

  task automatic t_comb();
    drive(2'd2, 6'h20, 32'h10, 32'h20);
    chk_res("R11 base", 32'h30, 1'b0);
    a_i = 32'h100;        // no clock edge in between
    #1;
    chk_res("R11 follow a", 32'h120, 1'b0);
    funct_i = 6'h22; b_i = 32'h100;
    #1;
    chk_res("R11 follow fn", 32'h0, 1'b1);
  endtask

  initial begin
    t_initial();
    t_decode();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_forced();
    t_class3();
    t_unknown();
    t_comb();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule